// File: doc/BRIEF.md
# Stereo Serial Audio Input Receiver

This block turns a three-wire stereo PCM stream into parallel samples. The three wires are a bit clock, a frame clock that marks channel halves, and one data line. All logic runs on the bit clock. Each sample arrives as two's complement with the most significant bit first, and the left word of a frame always comes before the right word. The block sign-extends every captured word to a 24-bit output and raises a one-cycle strobe once a frame holds both a left and a right word.

Four frame alignments are supported. In the standard inter-IC sound format the word starts one bit after the frame-clock edge. In the MSB-aligned format the word starts on the edge. In the LSB-aligned format the word ends on the edge. In the short-pulse format a one-bit frame pulse starts the left word. The format comes from two mode pins or from a 2-bit field held in a control register, and a source-select input chooses between them. A separate 2-bit code sets the word length to 16, 20 or 24 bits.

Top module: `pcmrx_top`

## Requirements
- R1: While `rst_n` is low, all state clears. In the first cycle after release, `frame_valid` is low and both output words are zero.
- R2: Words are taken MSB first as two's complement. `wlen_sel` sets the length: 00 = 16 bits, 01 = 20 bits, 10 or 11 = 24 bits. Bits above the length copy the sign bit in the 24-bit outputs.
- R3: When `fmt_from_reg` is 1 the format comes from `fmt_reg`; when it is 0 it comes from `fmt_pin`. The unselected input has no effect. Format codes: 00 = inter-IC sound, 01 = LSB-aligned, 10 = MSB-aligned, 11 = short-pulse.
- R4: Format 00. The left word is sent while `lrclk` is low. The MSB is the bit sampled on the second rising bit-clock edge after an `lrclk` change, and the first word-length bits from there form the word.
- R5: Format 10. The left word is sent while `lrclk` is high. The MSB is the bit sampled on the first rising edge at which `lrclk` differs from its previous value. Bits past the word length are ignored.
- R6: Format 01. The left word is sent while `lrclk` is high. The word is made of the last word-length bits sampled before the `lrclk` change. Earlier bits in the half are ignored.
- R7: Format 11. A high `lrclk` that follows a low one marks a frame start. The left MSB is the next bit, and the right MSB follows straight after the left LSB. A falling `lrclk` is ignored.
- R8: `frame_valid` is high for exactly one cycle, in the cycle after the right word of a frame completes, and only if a left word was captured since the previous strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; all state updates on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| lrclk | input | 1 | Frame clock / frame pulse |
| sdata | input | 1 | Serial data, MSB first |
| fmt_pin | input | 2 | Format code from external pins |
| fmt_reg | input | 2 | Format code from control register field |
| fmt_from_reg | input | 1 | 1 = use `fmt_reg`, 0 = use `fmt_pin` |
| wlen_sel | input | 2 | Word-length code (16/20/24) |
| left_word | output | 24 | Sign-extended left sample |
| right_word | output | 24 | Sign-extended right sample |
| frame_valid | output | 1 | One-cycle strobe when a frame pair is ready |

## Verification
The bench sweeps every format, word length and format source. The sample set covers the most positive and most negative values, all ones and zero. A design with an off-by-one start position would shift every word by one bit, which breaks the extreme values at once. Wrong sign extension shows up as corrupt upper bits on negative samples. Filler bits of ones are placed outside each word and set the opposite format on the unselected mode input, so leaked filler, a wrong LSB-aligned window, or a design that follows the falling edge of the short frame pulse would corrupt the captured words, and an inverted source select would decode every test in the wrong format. Counting the strobes per test catches missing, doubled or stretched `frame_valid` pulses.

// File: rtl/pcmrx_pkg.sv
package pcmrx_pkg;

    typedef enum logic [1:0] {
        FMT_I2S = 2'b00,
        FMT_RJ  = 2'b01,
        FMT_LJ  = 2'b10,
        FMT_DSP = 2'b11
    } fmt_e;

    // word length in bits for a length code
    function automatic int word_bits(input logic [1:0] code);
        case (code)
            2'b00:   return 16;
            2'b01:   return 20;
            default: return 24;
        endcase
    endfunction

endpackage

// File: rtl/pcmrx_fmt_pick.sv
module pcmrx_fmt_pick
    import pcmrx_pkg::*;
(
    input  logic [1:0] pin_code,
    input  logic [1:0] reg_code,
    input  logic       use_reg,
    output fmt_e       fmt
);
    always_comb begin
        fmt = fmt_e'(use_reg ? reg_code : pin_code);
    end
endmodule

// File: rtl/pcmrx_sext.sv
module pcmrx_sext #(
    parameter int OUT_W = 24,
    parameter int CW    = $clog2(OUT_W + 1)
) (
    input  logic [OUT_W-1:0] raw,
    input  logic [CW-1:0]    len,
    output logic [OUT_W-1:0] word
);
    logic sign_bit;

    always_comb begin
        sign_bit = raw[int'(len) - 1];
    end

    for (genvar i = 0; i < OUT_W; i++) begin : g_bit
        assign word[i] = (i < int'(len)) ? raw[i] : sign_bit;
    end
endmodule

// File: rtl/pcmrx_top.sv
module pcmrx_top
    import pcmrx_pkg::*;
#(
    parameter int OUT_W = 24
) (
    input  logic             bclk,
    input  logic             rst_n,
    input  logic             lrclk,
    input  logic             sdata,
    input  logic [1:0]       fmt_pin,
    input  logic [1:0]       fmt_reg,
    input  logic             fmt_from_reg,
    input  logic [1:0]       wlen_sel,
    output logic [OUT_W-1:0] left_word,
    output logic [OUT_W-1:0] right_word,
    output logic             frame_valid
);
    localparam int CW = $clog2(OUT_W + 1);

    typedef struct packed {
        logic             lr_prev;
        logic             arm;
        logic             arm_left;
        logic             busy;
        logic             cur_left;
        logic [CW-1:0]    cnt;
        logic [OUT_W-1:0] acc;
        logic [OUT_W-1:0] sh;
        logic             have_left;
        logic [OUT_W-1:0] left;
        logic [OUT_W-1:0] right;
        logic             valid;
    } st_t;

    st_t st_d, st_q;

    fmt_e             fmt;
    logic [CW-1:0]    wl;
    logic             lr_edge;
    logic             dlv_en;
    logic             dlv_left;
    logic [OUT_W-1:0] dlv_raw;
    logic [OUT_W-1:0] dlv_word;

    pcmrx_fmt_pick u_pick (
        .pin_code (fmt_pin),
        .reg_code (fmt_reg),
        .use_reg  (fmt_from_reg),
        .fmt      (fmt)
    );

    assign wl      = CW'(word_bits(wlen_sel));
    assign lr_edge = lrclk ^ st_q.lr_prev;

    // which word, if any, completes this cycle
    always_comb begin
        dlv_en   = 1'b0;
        dlv_left = 1'b0;
        dlv_raw  = {st_q.acc[OUT_W-2:0], sdata};
        if (fmt == FMT_RJ) begin
            dlv_en   = lr_edge;
            dlv_left = ~lrclk;
            dlv_raw  = st_q.sh;
        end else if (st_q.busy && (st_q.cnt + CW'(1) >= wl)) begin
            dlv_en   = 1'b1;
            dlv_left = st_q.cur_left;
        end
    end

    pcmrx_sext #(.OUT_W(OUT_W), .CW(CW)) u_sext (
        .raw  (dlv_raw),
        .len  (wl),
        .word (dlv_word)
    );

    always_comb begin
        logic start;
        logic start_left;
        st_d         = st_q;
        st_d.valid   = 1'b0;
        st_d.arm     = 1'b0;
        st_d.lr_prev = lrclk;
        st_d.sh      = {st_q.sh[OUT_W-2:0], sdata};
        start        = 1'b0;
        start_left   = 1'b0;

        if (st_q.busy) begin
            st_d.acc = {st_q.acc[OUT_W-2:0], sdata};
            st_d.cnt = st_q.cnt + CW'(1);
            if (st_q.cnt + CW'(1) >= wl) begin
                st_d.busy = 1'b0;
                if (fmt == FMT_DSP && st_q.cur_left) begin
                    st_d.arm      = 1'b1;
                    st_d.arm_left = 1'b0;
                end
            end
        end

        case (fmt)
            FMT_I2S: begin
                if (lr_edge) begin
                    st_d.arm      = 1'b1;
                    st_d.arm_left = ~lrclk;
                    st_d.busy     = 1'b0;
                end
                if (st_q.arm) begin
                    start      = 1'b1;
                    start_left = st_q.arm_left;
                end
            end
            FMT_LJ: begin
                if (lr_edge) begin
                    start      = 1'b1;
                    start_left = lrclk;
                end
            end
            FMT_DSP: begin
                if (lr_edge && lrclk) begin
                    st_d.arm      = 1'b1;
                    st_d.arm_left = 1'b1;
                    st_d.busy     = 1'b0;
                end
                if (st_q.arm) begin
                    start      = 1'b1;
                    start_left = st_q.arm_left;
                end
            end
            default: begin
                st_d.busy = 1'b0;
            end
        endcase

        if (start) begin
            st_d.busy     = 1'b1;
            st_d.cur_left = start_left;
            st_d.acc      = {{(OUT_W-1){1'b0}}, sdata};
            st_d.cnt      = CW'(1);
        end

        if (dlv_en) begin
            if (dlv_left) begin
                st_d.left      = dlv_word;
                st_d.have_left = 1'b1;
            end else begin
                st_d.right = dlv_word;
                if (st_q.have_left) begin
                    st_d.valid     = 1'b1;
                    st_d.have_left = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign left_word   = st_q.left;
    assign right_word  = st_q.right;
    assign frame_valid = st_q.valid;

    // R1: clean state straight after reset release
    assert_reset_clear_R1: assert property (@(posedge bclk) disable iff (!rst_n)
        $rose(rst_n) |-> (!frame_valid && left_word == '0 && right_word == '0));

    // R2: a word in progress never runs past the configured length
    assert_cnt_bound_R2: assert property (@(posedge bclk) disable iff (!rst_n)
        (st_q.busy && $stable(wlen_sel)) |-> (st_q.cnt < wl));

    // R8: strobe lasts a single cycle
    assert_valid_pulse_R8: assert property (@(posedge bclk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);

    // R6: LSB-aligned frames complete only on a rising frame-clock change
    assert_rj_edge_R6: assert property (@(posedge bclk) disable iff (!rst_n)
        (frame_valid && $past(fmt) == FMT_RJ)
        |-> ($past(lrclk) && !$past(lrclk, 2)));
endmodule

// File: tb/pcmrx_top_bench.sv
`timescale 1ns/1ps
module pcmrx_top_bench;
    localparam int NF = 6;

    logic        bclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lrclk = 1'b0;
    logic        sdata = 1'b0;
    logic [1:0]  fmt_pin = 2'b00;
    logic [1:0]  fmt_reg = 2'b00;
    logic        fmt_from_reg = 1'b0;
    logic [1:0]  wlen_sel = 2'b00;
    logic [23:0] left_word, right_word;
    logic        frame_valid;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    int vcount = 0;
    bit mon_on = 0;
    bit prev_v = 0;
    string rtag = "R4";
    logic [23:0] exp_l [NF];
    logic [23:0] exp_r [NF];

    pcmrx_top u_pcmrx_top (
        .bclk(bclk), .rst_n(rst_n), .lrclk(lrclk), .sdata(sdata),
        .fmt_pin(fmt_pin), .fmt_reg(fmt_reg), .fmt_from_reg(fmt_from_reg),
        .wlen_sel(wlen_sel), .left_word(left_word), .right_word(right_word),
        .frame_valid(frame_valid)
    );

    always #2 bclk = ~bclk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s got %h expected %h", req, what, act, expv);
        end
    endtask

    always @(posedge bclk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            tests++;
            $display("FAIL watchdog: cycles %0d expected below %0d", cycles, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // strobe monitor, sampled away from the active edge
    always @(negedge bclk) begin
        if (mon_on) begin
            if (frame_valid) begin
                check(!prev_v, {rtag, " R8"}, "strobe width", 32'd2, 32'd1);
                if (vcount < NF) begin
                    check(left_word == exp_l[vcount], {rtag, " R2 R3"}, "left word",
                          {8'h0, left_word}, {8'h0, exp_l[vcount]});
                    check(right_word == exp_r[vcount], {rtag, " R2 R3"}, "right word",
                          {8'h0, right_word}, {8'h0, exp_r[vcount]});
                end
                vcount++;
            end
            prev_v = frame_valid;
        end
    end

    function automatic logic [23:0] sx(input logic [23:0] raw, input int wl);
        int v;
        v = int'(raw) & ((1 << wl) - 1);
        if (v >= (1 << (wl - 1))) v = v - (1 << wl);
        return v[23:0];
    endfunction

    task automatic drive(input logic lr, input logic b);
        @(negedge bclk);
        lrclk = lr;
        sdata = b;
    endtask

    task automatic send_frame(input int md, input int wl,
                              input logic [23:0] l, input logic [23:0] r);
        if (md == 3) begin
            for (int s = 0; s < 64; s++) begin
                logic b;
                b = 1'b1;
                if (s >= 1 && s <= wl) b = l[wl - s];
                else if (s > wl && s <= 2 * wl) b = r[2 * wl - s];
                drive(s == 0, b);
            end
        end else begin
            for (int h = 0; h < 2; h++) begin
                logic [23:0] v;
                logic lv;
                v  = (h == 0) ? l : r;
                lv = (md == 0) ? (h == 1) : (h == 0);
                for (int s = 0; s < 32; s++) begin
                    logic b;
                    b = 1'b1;
                    if (md == 0 && s >= 1 && s <= wl) b = v[wl - s];
                    if (md == 2 && s < wl)            b = v[wl - 1 - s];
                    if (md == 1 && s >= 32 - wl)      b = v[31 - s];
                    drive(lv, b);
                end
            end
        end
    endtask

    initial begin
        for (int md = 0; md < 4; md++) begin
            for (int ws = 0; ws < 3; ws++) begin
                for (int src = 0; src < 2; src++) begin
                    int wl;
                    logic [23:0] mask;
                    logic [23:0] rl [NF];
                    logic [23:0] rr [NF];
                    wl = 16 + 4 * ws;
                    mask = 24'((1 << wl) - 1);
                    case (md)
                        0: rtag = "R4";
                        1: rtag = "R6";
                        2: rtag = "R5";
                        default: rtag = "R7";
                    endcase
                    // reset and configuration
                    @(negedge bclk);
                    rst_n = 1'b0;
                    mon_on = 0;
                    lrclk = (md == 0);
                    sdata = 1'b0;
                    wlen_sel = 2'(ws);
                    fmt_from_reg = src[0];
                    if (src == 1) begin fmt_reg = 2'(md); fmt_pin = ~2'(md); end
                    else          begin fmt_pin = 2'(md); fmt_reg = ~2'(md); end
                    repeat (3) @(negedge bclk);
                    rst_n = 1'b1;
                    @(negedge bclk);
                    check(frame_valid == 1'b0 && left_word == '0 && right_word == '0,
                          "R1", "outputs after reset",
                          {7'h0, frame_valid, left_word}, 32'h0);
                    // sample set
                    rl[0] = mask >> 1;           rr[0] = (mask >> 1) + 24'd1;
                    rl[1] = (mask >> 1) + 24'd1; rr[1] = mask >> 1;
                    rl[2] = mask;                rr[2] = 24'd1;
                    rl[3] = 24'd0;               rr[3] = mask;
                    rl[4] = 24'($urandom) & mask; rr[4] = 24'($urandom) & mask;
                    rl[5] = 24'($urandom) & mask; rr[5] = 24'($urandom) & mask;
                    for (int k = 0; k < NF; k++) begin
                        exp_l[k] = sx(rl[k], wl);
                        exp_r[k] = sx(rr[k], wl);
                    end
                    vcount = 0;
                    prev_v = 0;
                    mon_on = 1;
                    repeat (8) drive(md == 0, 1'b0);
                    for (int k = 0; k < NF; k++) send_frame(md, wl, rl[k], rr[k]);
                    repeat (40) drive((md == 1 || md == 2), 1'b0);
                    @(negedge bclk);
                    mon_on = 0;
                    check(vcount == NF, {rtag, " R8"}, "strobe count", vcount, NF);
                end
            end
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule